// File: doc/BRIEF.md
# AAL5 Packet Extraction Checker

This block sits between a source of whole ATM cells and a host processor. It takes one cell at a time, holds its 48 payload octets, and hands them to the host one octet per read strobe, lowest octet first. The host can copy the octets straight into memory and rebuild the packet. While the octets pass through, the block runs a CRC-32 over them and counts the cells of the packet. When the host reads the final octet of the last cell, the block posts a status word. The word holds the CRC verdict, a length-consistency verdict and the length field taken from the trailer.

Only one packet is in flight at a time. The cell source must not interleave cells of different packets. The cell side uses a valid/ready handshake. A host that reads slowly only holds ready low, so no cell or octet is ever dropped. Ready also stays low from the end of a packet until the host reads the status. Extraction keeps no link to any insertion path that may run beside it.

Top module: `aal5_extract`

## Requirements
- R1: After a synchronous reset, `cell_ready` is 1, `data_avail` is 0 and `stat_valid` is 0.
- R2: A cell is taken on a clock edge where `cell_valid` and `cell_ready` are both 1. From the next cycle, `data_avail` is 1 and `cell_ready` is 0. They stay that way until all 48 octets have been read. In the cycle after the 48th read, `data_avail` is 0.
- R3: Payload octet k (k = 0..47) sits on `cell_payload[8k+7:8k]`. `data_byte` shows octet 0 first. Each `data_rd` taken while `data_avail` is 1 moves `data_byte` on to the next octet.
- R4: `data_rd` has no effect while `data_avail` is 0. A cell offered while `cell_ready` is 0 is not taken, and `data_byte` does not change.
- R5: A cell closes its packet when `cell_hdr[1]` (the low bit of the payload-type field) is 1. Draining a cell with that bit at 0 leaves `stat_valid` at 0 and raises `cell_ready` again.
- R6: `stat_crc_ok` is 1 exactly when a CRC-32 over all octets of the packet except the last four equals the bitwise inverse of those four octets. The CRC uses polynomial 0x04C11DB7, starts at 0xFFFFFFFF and processes each octet most significant bit first. The last four octets are read big-endian: octet 44 of the last cell is the top byte.
- R7: `stat_len` equals octets 42 (high) and 43 (low) of the last cell. `stat_len_err` is 1 exactly when the packet's cell count N differs from ceil((`stat_len` + 8) / 48).
- R8: The status appears in the cycle after the final octet read, with `data_avail` already 0. `stat_valid` and a low `cell_ready` then hold until `stat_rd` is given. `stat_valid` is 0 in the cycle after that. `stat_rd` while `stat_valid` is 0 has no effect.
- R9: Each packet starts with a fresh CRC and a fresh cell count. The result for one packet does not depend on the packets before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_valid | input | 1 | Cell source offers a cell |
| cell_ready | output | 1 | Block can take a cell this cycle |
| cell_hdr | input | 32 | Cell header without HEC; bit 1 marks the last cell |
| cell_payload | input | 384 | 48 payload octets, octet k at bits 8k+7:8k |
| data_rd | input | 1 | Host read strobe for the payload octet stream |
| data_avail | output | 1 | An unread payload octet is present |
| data_byte | output | 8 | Current payload octet |
| stat_rd | input | 1 | Host read strobe for the status word; clears it |
| stat_valid | output | 1 | A packet result is waiting |
| stat_crc_ok | output | 1 | CRC of the finished packet matched |
| stat_len_err | output | 1 | Trailer length disagrees with the cell count |
| stat_len | output | 16 | Length field from the trailer |

## Verification
A wrong octet index shows on `data_byte` at the very next read, as a skipped or repeated octet. A fault in the buffer-full flag shows within a cycle as a ready/avail pair that is wrong, or as a lost cell. Faults in the CRC register or the cell counter do not show until the end of the packet. They then appear only as a wrong `stat_crc_ok` or `stat_len_err`, so the sweep crosses every length boundary for one, two and three cells, with good and damaged CRCs. Status-handshake faults show as `cell_ready` rising before `stat_rd`, or as `stat_valid` not clearing one cycle after it.

// File: rtl/aal5x_pkg.sv
package aal5x_pkg;

    localparam int CELL_BYTES = 48;
    localparam int PAY_W      = 8 * CELL_BYTES;
    localparam int HDR_W      = 32;
    localparam int IDX_W      = $clog2(CELL_BYTES);
    localparam int LAST_BIT   = 1;                 // low bit of the payload-type field
    localparam int LEN_POS    = CELL_BYTES - 6;    // length field, big-endian, 2 octets
    localparam int CRC_POS    = CELL_BYTES - 4;    // CRC field, big-endian, 4 octets
    localparam int TRAIL_B    = 8;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef struct packed {
        logic        crc_ok;
        logic        len_err;
        logic [15:0] len;
    } aal5x_status_t;

    // One octet through the CRC-32 shift register, MSB first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/aal5x_cell_buf.sv
module aal5x_cell_buf
    import aal5x_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [PAY_W-1:0]     in_payload,
    input  logic                 in_last,
    input  logic                 pop,
    output logic                 full,
    output logic [7:0]           cur_byte,
    output logic [IDX_W-1:0]     cur_idx,
    output logic                 is_last,
    output logic                 pop_final,
    output logic [15:0]          len_field,
    output logic [31:0]          crc_field
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

    logic [PAY_W-1:0] pay_q;
    logic [IDX_W-1:0] idx_q;
    logic             full_q;
    logic             last_q;
    logic             pop_ok;

    assign pop_ok    = pop && full_q;
    assign pop_final = pop_ok && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            pay_q  <= '0;
            idx_q  <= '0;
            full_q <= 1'b0;
            last_q <= 1'b0;
        end else if (load) begin
            pay_q  <= in_payload;
            idx_q  <= '0;
            full_q <= 1'b1;
            last_q <= in_last;
        end else if (pop_ok) begin
            if (idx_q == LAST_IDX) begin
                idx_q  <= '0;
                full_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign full     = full_q;
    assign cur_idx  = idx_q;
    assign is_last  = last_q;
    assign cur_byte = pay_q[8*int'(idx_q) +: 8];

    always_comb begin
        len_field = {pay_q[8*LEN_POS +: 8], pay_q[8*(LEN_POS+1) +: 8]};
        crc_field = '0;
        for (int b = 0; b < 4; b++) begin
            crc_field = {crc_field[23:0], pay_q[8*(CRC_POS+b) +: 8]};
        end
    end

    assert_load_fills_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> full_q && (idx_q == '0));
    assert_drain_empties_R2: assert property (@(posedge clk) disable iff (rst)
        (pop_final && !load) |=> !full_q);
    assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> !full_q);

endmodule

// File: rtl/aal5x_crc_acc.sv
module aal5x_crc_acc
    import aal5x_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= CRC_INIT;
        end else if (en) begin
            crc_q <= crc32_byte(crc_q, din);
        end
    end

    assign crc = crc_q;

    assert_crc_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!en && !clear) |=> $stable(crc_q));
    assert_crc_fresh_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (crc_q == CRC_INIT));

endmodule

// File: rtl/aal5x_trailer_chk.sv
module aal5x_trailer_chk
    import aal5x_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cell_acc,
    input  logic          pkt_end,
    input  logic [31:0]   crc_now,
    input  logic [31:0]   crc_field,
    input  logic [15:0]   len_field,
    input  logic          stat_rd,
    output aal5x_status_t status,
    output logic          stat_valid
);

    logic [CNT_W-1:0] cnt_q;
    aal5x_status_t    stat_q;
    logic             valid_q;
    logic [31:0]      total_b;
    logic [31:0]      need_b;
    logic             len_bad;

    always_comb begin
        total_b = 32'(cnt_q) * 32'(CELL_BYTES);
        need_b  = 32'(len_field) + 32'(TRAIL_B);
        len_bad = (need_b > total_b) || ((need_b + 32'(CELL_BYTES)) <= total_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            stat_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (pkt_end) begin
                cnt_q          <= '0;
                stat_q.crc_ok  <= (crc_now == ~crc_field);
                stat_q.len_err <= len_bad;
                stat_q.len     <= len_field;
                valid_q        <= 1'b1;
            end else begin
                if (cell_acc) cnt_q <= cnt_q + 1'b1;
                if (stat_rd)  valid_q <= 1'b0;
            end
        end
    end

    assign status     = stat_q;
    assign stat_valid = valid_q;

    assert_end_posts_R8: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> valid_q);
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_q && stat_rd && !pkt_end) |=> !valid_q);
    assert_status_held_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !stat_rd) |=> valid_q && $stable(stat_q));
    assert_count_fresh_R9: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> (cnt_q == '0));

endmodule

// File: rtl/aal5_extract.sv
module aal5_extract
    import aal5x_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cell_valid,
    output logic             cell_ready,
    input  logic [HDR_W-1:0] cell_hdr,
    input  logic [PAY_W-1:0] cell_payload,
    input  logic             data_rd,
    output logic             data_avail,
    output logic [7:0]       data_byte,
    input  logic             stat_rd,
    output logic             stat_valid,
    output logic             stat_crc_ok,
    output logic             stat_len_err,
    output logic [15:0]      stat_len
);

    logic             buf_full;
    logic             load;
    logic [IDX_W-1:0] idx;
    logic             is_last;
    logic             pop_final;
    logic [15:0]      len_field;
    logic [31:0]      crc_field;
    logic [31:0]      crc_now;
    logic             crc_en;
    logic             pkt_end;
    aal5x_status_t    status;

    assign cell_ready = !buf_full && !stat_valid;
    assign load       = cell_valid && cell_ready;
    assign data_avail = buf_full;
    assign pkt_end    = pop_final && is_last;
    assign crc_en     = data_rd && buf_full && (!is_last || (int'(idx) < CRC_POS));

    aal5x_cell_buf u_buf (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .in_payload (cell_payload),
        .in_last    (cell_hdr[LAST_BIT]),
        .pop        (data_rd),
        .full       (buf_full),
        .cur_byte   (data_byte),
        .cur_idx    (idx),
        .is_last    (is_last),
        .pop_final  (pop_final),
        .len_field  (len_field),
        .crc_field  (crc_field)
    );

    aal5x_crc_acc u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (pkt_end),
        .en    (crc_en),
        .din   (data_byte),
        .crc   (crc_now)
    );

    aal5x_trailer_chk #(.CNT_W(CNT_W)) u_chk (
        .clk        (clk),
        .rst        (rst),
        .cell_acc   (load),
        .pkt_end    (pkt_end),
        .crc_now    (crc_now),
        .crc_field  (crc_field),
        .len_field  (len_field),
        .stat_rd    (stat_rd),
        .status     (status),
        .stat_valid (stat_valid)
    );

    assign stat_crc_ok  = status.crc_ok;
    assign stat_len_err = status.len_err;
    assign stat_len     = status.len;

    assert_byte_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && !(data_rd && data_avail)) |=> $stable(data_byte));
    assert_drained_at_status_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_valid) |-> !data_avail);
    assert_mid_packet_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (pop_final && !is_last && !stat_valid) |=> !stat_valid);

endmodule

// File: tb/aal5_extract_bench.sv
`timescale 1ns/1ps
module aal5_extract_bench;

    localparam int CB = 48;

    logic         clk = 1'b0;
    logic         rst;
    logic         cell_valid;
    logic         cell_ready;
    logic [31:0]  cell_hdr;
    logic [383:0] cell_payload;
    logic         data_rd;
    logic         data_avail;
    logic [7:0]   data_byte;
    logic         stat_rd;
    logic         stat_valid;
    logic         stat_crc_ok;
    logic         stat_len_err;
    logic [15:0]  stat_len;

    int checks = 0;
    int fails  = 0;
    logic [7:0] pk [0:191];

    always #2 clk = ~clk;

    aal5_extract u_aal5_extract (
        .clk(clk), .rst(rst), .cell_valid(cell_valid), .cell_ready(cell_ready),
        .cell_hdr(cell_hdr), .cell_payload(cell_payload), .data_rd(data_rd),
        .data_avail(data_avail), .data_byte(data_byte), .stat_rd(stat_rd),
        .stat_valid(stat_valid), .stat_crc_ok(stat_crc_ok),
        .stat_len_err(stat_len_err), .stat_len(stat_len)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {d, 24'h0};
        for (int i = 0; i < 8; i++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    task automatic build(input int n, input int len, input int seed, input bit corrupt);
        int t;
        logic [31:0] c;
        t = n * CB;
        for (int i = 0; i < t - 8; i++) pk[i] = 8'((i * 13 + seed) & 8'hff);
        pk[t-8] = 8'(seed);
        pk[t-7] = 8'h00;
        pk[t-6] = 8'(len >> 8);
        pk[t-5] = 8'(len);
        c = 32'hFFFFFFFF;
        for (int i = 0; i < t - 4; i++) c = ref_crc(c, pk[i]);
        c = ~c;
        pk[t-4] = c[31:24]; pk[t-3] = c[23:16]; pk[t-2] = c[15:8]; pk[t-1] = c[7:0];
        if (corrupt) pk[t-1] = pk[t-1] ^ 8'h01;
    endtask

    task automatic drive_cell(input int c, input bit last);
        cell_valid = 1'b1;
        cell_hdr   = {28'h0012345, 1'b0, 1'b0, last, 1'b0};
        for (int k = 0; k < CB; k++) cell_payload[8*k +: 8] = pk[c*CB + k];
    endtask

    task automatic xfer_cell(input int c, input bit last);
        @(negedge clk);
        drive_cell(c, last);
        while (!cell_ready) @(negedge clk);
        @(negedge clk);
        cell_valid = 1'b0;
        chk(data_avail && !cell_ready, "R2 cell taken", {data_avail, cell_ready}, 2'b10);
    endtask

    task automatic read_cell(input int c, input bit gap, input bit last);
        int bad = 0;
        for (int k = 0; k < CB; k++) begin
            if (gap && (k % 7 == 3)) @(negedge clk);
            if (!data_avail || data_byte !== pk[c*CB + k]) begin
                if (bad == 0)
                    chk(1'b0, "R3 octet order", data_byte, pk[c*CB + k]);
                bad++;
            end
            data_rd = 1'b1;
            @(negedge clk);
            data_rd = 1'b0;
        end
        chk(bad == 0, "R3 cell octets", bad, 0);
        chk(!data_avail, "R2 drained", data_avail, 0);
        if (!last)
            chk(!stat_valid && cell_ready, "R5 mid-packet cell", {stat_valid, cell_ready}, 2'b01);
    endtask

    task automatic check_status(input int n, input int len, input bit corrupt);
        logic exp_err;
        exp_err = (((len + 8 + CB - 1) / CB) != n);
        chk(stat_valid && !cell_ready, "R8 status posted", {stat_valid, cell_ready}, 2'b10);
        chk(stat_crc_ok == !corrupt, "R6 crc verdict", stat_crc_ok, !corrupt);
        chk(stat_len_err == exp_err, "R7 length verdict", stat_len_err, exp_err);
        chk(stat_len == 16'(len), "R7 length field", stat_len, len);
    endtask

    task automatic ack_status;
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(!stat_valid && cell_ready, "R8 status cleared", {stat_valid, cell_ready}, 2'b01);
    endtask

    task automatic run_packet(input int n, input int len, input int seed, input bit corrupt, input bit gap);
        build(n, len, seed, corrupt);
        for (int c = 0; c < n; c++) begin
            xfer_cell(c, c == n - 1);
            read_cell(c, gap, c == n - 1);
        end
        check_status(n, len, corrupt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int pkt = 0;
        rst = 1'b1; cell_valid = 1'b0; cell_hdr = '0; cell_payload = '0;
        data_rd = 1'b0; stat_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cell_ready && !data_avail && !stat_valid, "R1 reset state",
            {cell_ready, data_avail, stat_valid}, 3'b100);

        // R4 / R8: strobes on an idle block change nothing
        data_rd = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0; stat_rd = 1'b0;
        chk(!data_avail && !stat_valid && cell_ready, "R4 idle strobes ignored",
            {data_avail, stat_valid, cell_ready}, 3'b001);

        // First packet, status left unread
        run_packet(1, 20, 5, 1'b0, 1'b0);

        // R8: a cell offered while status waits is not taken
        build(2, 60, 9, 1'b0);
        drive_cell(0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!data_avail && !cell_ready, "R8 blocked until status read",
                {data_avail, cell_ready}, 2'b00);
        end
        ack_status();
        @(negedge clk);
        chk(data_avail && data_byte == pk[0], "R2 taken after status read", data_byte, pk[0]);
        // R4: next cell offered while full is ignored
        drive_cell(1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!cell_ready && data_byte == pk[0], "R4 full buffer holds", data_byte, pk[0]);
        end
        cell_valid = 1'b0;
        read_cell(0, 1'b0, 1'b0);
        xfer_cell(1, 1'b1);
        read_cell(1, 1'b1, 1'b1);
        check_status(2, 60, 1'b0);
        ack_status();

        // Sweep: R6 R7 R9 across length boundaries for 1..3 cells
        for (int n = 1; n <= 3; n++) begin
            int lo;
            lo = (n - 1) * CB - 12;
            if (lo < 0) lo = 0;
            for (int len = lo; len <= n * CB - 4; len++) begin
                run_packet(n, len, pkt * 3 + 1, (pkt % 5) == 2, (pkt % 2) == 1);
                ack_status();
                pkt++;
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule